// File: doc/BRIEF.md
# Four-Lane Data Block Transmitter with Write Acknowledge

The block sends one host-to-card data block over a four-line data bus in which every line is a serial channel with its own checksum. Bytes come in on a ready/valid stream. Once started, the block drives a start nibble and then the block's bytes as nibbles. It then sends the sixteen checksum nibbles and an end nibble, and releases the bus. Each of the four lines keeps its own 16-bit CRC, built only from the bits that line carried.

After the release, the block listens on data line 0. It waits for the card's start bit and captures a three-bit status token and its end bit. It then waits out the card's busy period, in which line 0 is held low. A programmable limit, counted in bus clocks, bounds both the wait for the token and the busy period. The result is reported as the captured token, an error flag and a timeout flag, qualified by a one-cycle done pulse. Each clock cycle in which `bus_tick` is high is one bus bit time. The surrounding logic forwards that tick to the bus clock pin.

Top module: `sdq_blk_tx`

## Requirements
- R1: After reset, and whenever no transfer runs, `dat_oe`, `xfer_busy`, `in_ready` and `bus_tick` are low and `dat_out` is 4'hF.
- R2: A transfer of `blk_len_m1`+1 bytes drives, on successive ticks with `dat_oe` high, the nibbles in this order: one nibble 4'h0, then every byte upper nibble first (bit 3 of the nibble on line 3, bit 0 on line 0), then sixteen checksum nibbles, then one nibble 4'hF. This holds for the full range of 1 to 512 bytes.
- R3: Line i carries a CRC16 with polynomial x^16+x^12+x^5+1 (0x1021), cleared to zero at the start. It is updated with bit i of each data nibble and shifted out most significant bit first in the sixteen checksum nibbles, with bit i of each nibble holding line i's bit.
- R4: When the next byte has not arrived, `bus_tick` is low for that cycle and neither the nibble sequence nor the CRCs advance. The transmitted sequence is the same as for an unbroken stream.
- R5: From the tick after the end nibble until the transfer finishes, `dat_oe` stays low. The first two of those ticks are idle gap bits that the block does not sample.
- R6: After the gap, the block waits for a 0 on `dat0_in`. It shifts the next three bits, most significant first, into `ack_token`, then samples one end bit. `crc_err` is set when the token differs from 3'b010 or the end bit is 0.
- R7: After the token, the block waits for `dat0_in` to read 1. It then raises `xfer_done` for exactly one cycle, and `xfer_busy` is low in the following cycle.
- R8: With `busy_limit` L, a timeout occurs if L consecutive samples are spent waiting for the start bit, or L consecutive low samples are seen in the busy period. The transfer then ends with `timeout` high. L-1 such samples end normally. A timeout in the start-bit wait leaves `ack_token` at 3'b000 and `crc_err` low.
- R9: `xfer_start` while `xfer_busy` is high is ignored and the running transfer's length is unchanged.
- R10: Exactly `blk_len_m1`+1 bytes are accepted per transfer, and `in_ready` is low once they have been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_start | input | 1 | Begin a block transfer when idle |
| blk_len_m1 | input | 9 | Block length in bytes minus one |
| busy_limit | input | 16 | Wait limit in bus clocks for token and busy phases |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Block accepts a byte this cycle |
| dat_out | output | 4 | Data lines driven toward the card |
| dat_oe | output | 1 | Host drives the data lines |
| dat0_in | input | 1 | Sampled level of data line 0 |
| bus_tick | output | 1 | This cycle is a bus bit time |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle end-of-transfer pulse |
| ack_token | output | 3 | Captured status token |
| crc_err | output | 1 | Token not 3'b010 or bad end bit |
| timeout | output | 1 | Token or busy wait exceeded the limit |

## Verification
Two things can happen at the same clock edge: the refill of the one-byte holding register from the input stream, and the consumption of its low nibble. With `in_valid` held high, the bench requires every data nibble on consecutive ticks, so a refill lost or doubled at that edge shows up as a missing or repeated byte in the captured nibble stream. A second pairing is a late `xfer_start` arriving while a transfer runs. One vector raises it mid-block, and the bench judges the result by the nibble count and the checksum of the original length.

// File: rtl/sdq_pkg.sv
// Shared types and constants of the four-lane block transmitter.
// Assumes one clock cycle equals one bus bit time.
package sdq_pkg;
    localparam int          LANES     = 4;
    localparam int          CRC_W     = 16;
    localparam logic [15:0] CRC_POLY  = 16'h1021;
    localparam int          TOK_W     = 3;
    localparam logic [2:0]  TOK_GOOD  = 3'b010;

    typedef enum logic [2:0] {
        TX_IDLE, TX_SOF, TX_DATA, TX_CRC, TX_EOF, TX_GAP, TX_ACK
    } tx_state_e;

    typedef enum logic [2:0] {
        AK_IDLE, AK_WAIT_SB, AK_TOKEN, AK_ENDBIT, AK_BUSY
    } ack_state_e;
endpackage

// File: rtl/sdq_crc16_lane.sv
// One serial CRC16 for a single data line.
// It clears on clr, absorbs bit d on upd, and shifts its register left with
// zero fill on shift so that bit 15 is the next bit to send.
// Assumes that at most one of upd and shift is high in a cycle.
module sdq_crc16_lane
    import sdq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd,
    input  logic             shift,
    input  logic             d,
    output logic [CRC_W-1:0] crc_q
);
    logic fb;
    assign fb = d ^ crc_q[CRC_W-1];

    // Checksum register: clear, update with one bit, or drain
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            crc_q <= '0;
        else if (upd)
            crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        else if (shift)
            crc_q <= {crc_q[CRC_W-2:0], 1'b0};
    end
endmodule

// File: rtl/sdq_ack_rx.sv
// Receives the card's write acknowledge on data line 0 and waits for busy.
// After go, it waits for a 0 start bit, shifts in a token, samples an end bit,
// then waits for line 0 to read high. Both waits are bounded by limit.
// Assumes limit is stable while active is high.
module sdq_ack_rx
    import sdq_pkg::*;
#(
    parameter int LIM_W = 16
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             dat0,
    input  logic [LIM_W-1:0] limit,
    output logic             active,
    output logic             done,
    output logic [TOK_W-1:0] token,
    output logic             tok_err,
    output logic             timeout
);
    localparam int BC_W = $clog2(TOK_W);

    ack_state_e       st;
    logic [LIM_W-1:0] cnt;
    logic [BC_W-1:0]  bitc;
    logic             lim_hit;

    assign lim_hit = ({1'b0, cnt} + (LIM_W+1)'(1)) >= {1'b0, limit};
    assign active  = (st != AK_IDLE);

    // Acknowledge sequencer with wait counter and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= AK_IDLE;
            cnt     <= '0;
            bitc    <= '0;
            token   <= '0;
            tok_err <= 1'b0;
            timeout <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                AK_IDLE: if (go) begin
                    st      <= AK_WAIT_SB;
                    cnt     <= '0;
                    token   <= '0;
                    tok_err <= 1'b0;
                    timeout <= 1'b0;
                end
                AK_WAIT_SB: begin
                    if (!dat0) begin
                        st   <= AK_TOKEN;
                        bitc <= '0;
                    end else if (lim_hit) begin
                        timeout <= 1'b1;
                        done    <= 1'b1;
                        st      <= AK_IDLE;
                    end else
                        cnt <= cnt + 1'b1;
                end
                AK_TOKEN: begin
                    token <= {token[TOK_W-2:0], dat0};
                    bitc  <= bitc + 1'b1;
                    if (bitc == BC_W'(TOK_W-1))
                        st <= AK_ENDBIT;
                end
                AK_ENDBIT: begin
                    tok_err <= (token != TOK_GOOD) || !dat0;
                    cnt     <= '0;
                    st      <= AK_BUSY;
                end
                AK_BUSY: begin
                    if (dat0) begin
                        done <= 1'b1;
                        st   <= AK_IDLE;
                    end else if (lim_hit) begin
                        timeout <= 1'b1;
                        done    <= 1'b1;
                        st      <= AK_IDLE;
                    end else
                        cnt <= cnt + 1'b1;
                end
                default: st <= AK_IDLE;
            endcase
        end
    end

    // R7: the completion strobe never lasts two cycles
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: token capture begins only right after a sampled 0 start bit
    p_token_sb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == AK_TOKEN && bitc == '0) |-> ($past(st) == AK_WAIT_SB && !$past(dat0)));

    // R8: a newly raised timeout always ends the transfer in the same cycle
    p_timeout_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> done);
endmodule

// File: rtl/sdq_blk_tx.sv
// Four-lane data block transmitter with write acknowledge.
// It sends start nibble, data nibbles, four per-line CRC16 and end nibble,
// releases the bus, then hands line 0 to the acknowledge receiver.
// Assumes in_data/in_valid follow ready/valid rules and that one clock
// cycle is one bus bit when bus_tick is high.
module sdq_blk_tx
    import sdq_pkg::*;
#(
    parameter  int MAX_LEN = 512,
    parameter  int LIM_W   = 16,
    parameter  int GAP_CYC = 2,
    localparam int LEN_W   = $clog2(MAX_LEN)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_start,
    input  logic [LEN_W-1:0] blk_len_m1,
    input  logic [LIM_W-1:0] busy_limit,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [3:0]       dat_out,
    output logic             dat_oe,
    input  logic             dat0_in,
    output logic             bus_tick,
    output logic             xfer_busy,
    output logic             xfer_done,
    output logic [TOK_W-1:0] ack_token,
    output logic             crc_err,
    output logic             timeout
);
    localparam int GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
    localparam int CC_W  = $clog2(CRC_W);

    tx_state_e                    st;
    logic [LEN_W-1:0]             len_q;
    logic [LEN_W:0]               fetched;
    logic [7:0]                   hold_byte;
    logic                         hold_vld;
    logic [LEN_W-1:0]             byte_idx;
    logic                         nib_lo;
    logic [CC_W-1:0]              crc_cnt;
    logic [GAP_W-1:0]             gap_cnt;
    logic                         start_acc;
    logic                         more;
    logic                         stall;
    logic                         last_byte;
    logic [3:0]                   cur_nib;
    logic [LANES-1:0]             crc_msb;
    logic [LANES-1:0][CRC_W-1:0]  lane_crc;
    logic                         ack_go;
    logic                         ack_active;

    assign start_acc = xfer_start && (st == TX_IDLE);
    assign more      = fetched < ({1'b0, len_q} + (LEN_W+1)'(1));
    assign stall     = (st == TX_DATA) && !hold_vld;
    assign last_byte = (byte_idx == len_q);
    assign cur_nib   = nib_lo ? hold_byte[3:0] : hold_byte[7:4];
    assign bus_tick  = (st != TX_IDLE) && !stall;
    assign xfer_busy = (st != TX_IDLE);
    assign ack_go    = (st == TX_GAP) && (gap_cnt == GAP_W'(GAP_CYC-1));

    // Byte request: during start and data, when the holding slot is free or emptying
    assign in_ready = ((st == TX_SOF) || (st == TX_DATA)) && more &&
                      (!hold_vld || ((st == TX_DATA) && nib_lo));

    // Line drive: fixed framing nibbles, data nibble or checksum bits
    always_comb begin
        dat_oe  = 1'b1;
        dat_out = 4'hF;
        case (st)
            TX_SOF:  dat_out = 4'h0;
            TX_DATA: dat_out = cur_nib;
            TX_CRC:  dat_out = crc_msb;
            TX_EOF:  dat_out = 4'hF;
            default: dat_oe  = 1'b0;
        endcase
    end

    // Transfer sequencer: framing states, nibble position and phase counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= TX_IDLE;
            len_q    <= '0;
            byte_idx <= '0;
            nib_lo   <= 1'b0;
            crc_cnt  <= '0;
            gap_cnt  <= '0;
        end else begin
            case (st)
                TX_IDLE: if (start_acc) begin
                    len_q    <= blk_len_m1;
                    byte_idx <= '0;
                    nib_lo   <= 1'b0;
                    st       <= TX_SOF;
                end
                TX_SOF: st <= TX_DATA;
                TX_DATA: if (bus_tick) begin
                    nib_lo <= ~nib_lo;
                    if (nib_lo) begin
                        byte_idx <= byte_idx + 1'b1;
                        if (last_byte) begin
                            crc_cnt <= '0;
                            st      <= TX_CRC;
                        end
                    end
                end
                TX_CRC: begin
                    crc_cnt <= crc_cnt + 1'b1;
                    if (crc_cnt == CC_W'(CRC_W-1))
                        st <= TX_EOF;
                end
                TX_EOF: begin
                    gap_cnt <= '0;
                    st      <= TX_GAP;
                end
                TX_GAP: begin
                    gap_cnt <= gap_cnt + 1'b1;
                    if (ack_go)
                        st <= TX_ACK;
                end
                TX_ACK: if (xfer_done) st <= TX_IDLE;
                default: st <= TX_IDLE;
            endcase
        end
    end

    // Input holding slot: refill on handshake, empty after the low nibble goes out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_byte <= '0;
            hold_vld  <= 1'b0;
            fetched   <= '0;
        end else if (start_acc) begin
            hold_vld <= 1'b0;
            fetched  <= '0;
        end else if (in_ready && in_valid) begin
            hold_byte <= in_data;
            hold_vld  <= 1'b1;
            fetched   <= fetched + 1'b1;
        end else if ((st == TX_DATA) && bus_tick && nib_lo)
            hold_vld <= 1'b0;
    end

    // Per-line checksum generators, one per data line
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        sdq_crc16_lane u_crc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (start_acc),
            .upd   ((st == TX_DATA) && bus_tick),
            .shift (st == TX_CRC),
            .d     (cur_nib[i]),
            .crc_q (lane_crc[i])
        );
        assign crc_msb[i] = lane_crc[i][CRC_W-1];
    end

    sdq_ack_rx #(.LIM_W(LIM_W)) u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (ack_go),
        .dat0    (dat0_in),
        .limit   (busy_limit),
        .active  (ack_active),
        .done    (xfer_done),
        .token   (ack_token),
        .tok_err (crc_err),
        .timeout (timeout)
    );

    // R2: an accepted start drives the all-zero start nibble next cycle
    p_start_nib_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> (dat_oe && dat_out == 4'h0));

    // R3: sixteen drain shifts leave every lane register empty at the end nibble
    p_crc_drained_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_EOF) |-> (lane_crc == '0));

    // R4: a stalled cycle leaves the nibble position untouched
    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_DATA && !bus_tick) |=> (st == TX_DATA && $stable(byte_idx) && $stable(nib_lo)));

    // R5: the host never drives while the acknowledge receiver listens
    p_quiet_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_active |-> !dat_oe);

    // R9: a start during a transfer does not reload the length
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && xfer_busy) |=> $stable(len_q));

    // R10: by the checksum phase exactly the programmed byte count was taken
    p_fetch_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_CRC) |-> (fetched == ({1'b0, len_q} + (LEN_W+1)'(1))));
endmodule

// File: tb/sdq_blk_tx_tb_top.sv
`timescale 1ns/1ps
// Bench for sdq_blk_tx: a vector table walked by one loop, then directed cases.
module sdq_blk_tx_tb_top;
    typedef struct packed {
        logic [9:0]  nbytes;
        logic [15:0] lim;
        logic [7:0]  pre;
        logic [2:0]  tok;
        logic        endb;
        logic [15:0] bsy;
        logic        stall;
        logic        rs;
        logic [7:0]  seed;
        logic        e_to;
        logic [2:0]  e_tok;
        logic        e_err;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{10'd4,   16'd20, 8'd0, 3'b010, 1'b1, 16'd5, 1'b0, 1'b0, 8'hA6, 1'b0, 3'b010, 1'b0},
        '{10'd1,   16'd20, 8'd3, 3'b010, 1'b1, 16'd0, 1'b0, 1'b0, 8'h3C, 1'b0, 3'b010, 1'b0},
        '{10'd17,  16'd50, 8'd1, 3'b010, 1'b1, 16'd10,1'b1, 1'b1, 8'h11, 1'b0, 3'b010, 1'b0},
        '{10'd8,   16'd20, 8'd0, 3'b101, 1'b1, 16'd2, 1'b0, 1'b0, 8'h5A, 1'b0, 3'b101, 1'b1},
        '{10'd4,   16'd20, 8'd0, 3'b010, 1'b0, 16'd2, 1'b0, 1'b0, 8'h77, 1'b0, 3'b010, 1'b1},
        '{10'd6,   16'd8,  8'd0, 3'b010, 1'b1, 16'd7, 1'b0, 1'b0, 8'h90, 1'b0, 3'b010, 1'b0},
        '{10'd6,   16'd8,  8'd0, 3'b010, 1'b1, 16'd8, 1'b0, 1'b0, 8'h91, 1'b1, 3'b010, 1'b0},
        '{10'd3,   16'd5,  8'd5, 3'b010, 1'b1, 16'd0, 1'b0, 1'b0, 8'hC3, 1'b1, 3'b000, 1'b0},
        '{10'd512, 16'd30, 8'd2, 3'b010, 1'b1, 16'd3, 1'b0, 1'b0, 8'hE1, 1'b0, 3'b010, 1'b0},
        '{10'd32,  16'd40, 8'd0, 3'b011, 1'b1, 16'd1, 1'b1, 1'b0, 8'h2F, 1'b0, 3'b011, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xfer_start = 1'b0;
    logic [8:0] blk_len_m1 = '0;
    logic [15:0] busy_limit = 16'd10;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [3:0] dat_out;
    logic       dat_oe;
    logic       dat0_in = 1'b1;
    logic       bus_tick;
    logic       xfer_busy;
    logic       xfer_done;
    logic [2:0] ack_token;
    logic       crc_err;
    logic       timeout;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] bytes [512];
    logic [3:0] expv  [1042];
    logic [3:0] got   [1042];

    always #4 clk = ~clk;

    sdq_blk_tx dut_i (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .blk_len_m1(blk_len_m1),
        .busy_limit(busy_limit), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .dat_out(dat_out), .dat_oe(dat_oe), .dat0_in(dat0_in),
        .bus_tick(bus_tick), .xfer_busy(xfer_busy), .xfer_done(xfer_done),
        .ack_token(ack_token), .crc_err(crc_err), .timeout(timeout)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Card answer on line 0 at position j after the gap
    function automatic logic card_bit(input vec_t v, input int j);
        int p = int'(v.pre);
        if (j < p) return 1'b1;
        if (j == p) return 1'b0;
        if (j <= p + 3) return v.tok[2 - (j - p - 1)];
        if (j == p + 4) return v.endb;
        if (j <= p + 4 + int'(v.bsy)) return 1'b0;
        return 1'b1;
    endfunction

    // Builds the data and the expected nibble stream with four lane checksums
    task automatic build_expect(input vec_t v, output int exp_n);
        int n = int'(v.nbytes);
        logic [15:0] c [4];
        for (int i = 0; i < 4; i++) c[i] = '0;
        expv[0] = 4'h0;
        for (int k = 0; k < n; k++) begin
            bytes[k] = v.seed ^ 8'(k * 37) ^ 8'(k >> 3);
            expv[1 + 2*k]     = bytes[k][7:4];
            expv[1 + 2*k + 1] = bytes[k][3:0];
        end
        for (int m = 1; m <= 2*n; m++) begin
            for (int i = 0; i < 4; i++) begin
                logic fb;
                fb = expv[m][i] ^ c[i][15];
                c[i] = {c[i][14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
            end
        end
        for (int k = 0; k < 16; k++)
            for (int i = 0; i < 4; i++)
                expv[1 + 2*n + k][i] = c[i][15-k];
        expv[2*n + 17] = 4'hF;
        exp_n = 2*n + 18;
    endtask

    task automatic run_vec(input int vi, input vec_t v);
        int n = int'(v.nbytes);
        int exp_n, gn, idx, since_end, stalls, first_bad2, first_bad3, iter;
        logic oe_viol, done_seen;
        logic [2:0] tok_s;
        logic err_s, to_s;
        build_expect(v, exp_n);
        gn = 0; idx = 0; since_end = -1; stalls = 0; oe_viol = 1'b0; done_seen = 1'b0;
        first_bad2 = -1; first_bad3 = -1; tok_s = '0; err_s = 1'b0; to_s = 1'b0;
        @(negedge clk);
        blk_len_m1 = 9'(n - 1);
        busy_limit = v.lim;
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        iter = 0;
        while (!done_seen && iter < 20000) begin
            if (since_end >= 0) since_end++;
            if (v.rs && iter == 5) begin
                xfer_start = 1'b1;
                blk_len_m1 = 9'd0;
            end else
                xfer_start = 1'b0;
            in_valid = (idx < n) && (!v.stall || (iter % 3 == 0));
            in_data  = (idx < n) ? bytes[idx] : 8'h00;
            if (in_ready && in_valid) idx++;
            if (!bus_tick && since_end < 0) stalls++;
            if (since_end >= 1 && dat_oe) oe_viol = 1'b1;
            if (dat_oe && bus_tick && since_end < 0) begin
                if (gn < 1042) got[gn] = dat_out;
                gn++;
                if (gn == exp_n) since_end = 0;
            end
            dat0_in = (since_end >= 3) ? card_bit(v, since_end - 3) : 1'b1;
            if (xfer_done) begin
                done_seen = 1'b1;
                tok_s = ack_token; err_s = crc_err; to_s = timeout;
            end
            @(negedge clk);
            iter++;
        end
        xfer_start = 1'b0;
        in_valid = 1'b0;
        dat0_in = 1'b1;
        for (int j = 0; j < exp_n && j < gn; j++) begin
            if (got[j] !== expv[j]) begin
                if (j > 2*n && j < 2*n + 17) begin
                    if (first_bad3 < 0) first_bad3 = j;
                end else if (first_bad2 < 0) first_bad2 = j;
            end
        end
        check(done_seen, "R7", $sformatf("vec %0d done pulse seen", vi), done_seen, 1);
        check(gn == exp_n, "R2", $sformatf("vec %0d nibble count", vi), gn, exp_n);
        check(first_bad2 < 0, v.stall ? "R2/R4" : "R2",
              $sformatf("vec %0d framing/data nibble %0d", vi, first_bad2),
              (first_bad2 < 0) ? 0 : got[first_bad2], (first_bad2 < 0) ? 0 : expv[first_bad2]);
        check(first_bad3 < 0, "R3", $sformatf("vec %0d checksum nibble %0d", vi, first_bad3),
              (first_bad3 < 0) ? 0 : got[first_bad3], (first_bad3 < 0) ? 0 : expv[first_bad3]);
        check(!oe_viol, "R5", $sformatf("vec %0d bus released after end nibble", vi), oe_viol, 0);
        check(tok_s == v.e_tok, "R6", $sformatf("vec %0d token", vi), tok_s, v.e_tok);
        check(err_s == v.e_err, "R6", $sformatf("vec %0d crc_err", vi), err_s, v.e_err);
        check(to_s == v.e_to, "R8", $sformatf("vec %0d timeout", vi), to_s, v.e_to);
        check(idx == n, "R10", $sformatf("vec %0d bytes accepted", vi), idx, n);
        check(!xfer_busy && !in_ready, "R7", $sformatf("vec %0d idle after done", vi),
              {xfer_busy, in_ready}, 0);
        if (v.stall)
            check(stalls > 0, "R4", $sformatf("vec %0d stall cycles seen", vi), stalls, 1);
        if (v.rs)
            check(gn == exp_n && first_bad3 < 0, "R9",
                  $sformatf("vec %0d late start ignored", vi), gn, exp_n);
    endtask

    // Global watchdog: counts as a failed check and still prints the summary
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!dat_oe && !xfer_busy && !in_ready && !bus_tick && dat_out == 4'hF, "R1",
              "reset outputs {oe,busy,ready,tick,dat}",
              {dat_oe, xfer_busy, in_ready, bus_tick, dat_out}, 5'h0F);
        check(!xfer_done && !timeout && !crc_err && ack_token == 3'b000, "R1",
              "reset status", {xfer_done, timeout, crc_err, ack_token}, 0);

        for (int vi = 0; vi < NV; vi++)
            run_vec(vi, VECS[vi]);

        // R1: idle outputs after a completed transfer
        @(negedge clk);
        check(!dat_oe && !bus_tick && dat_out == 4'hF, "R1", "idle outputs after transfers",
              {dat_oe, bus_tick, dat_out}, 6'h0F);

        // R1: reset mid-transfer returns to idle
        blk_len_m1 = 9'd20;
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!dat_oe && !xfer_busy && !in_ready, "R1", "reset during transfer",
              {dat_oe, xfer_busy, in_ready}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule